// File: doc/BRIEF.md
# Flash Command Decoder with Status

This block sits on the bus side of a parallel NOR-style flash model. It reads each bus write as a command and keeps three sticky error flags. It also keeps one protection bit for each erase block. It handles three kinds of command:

- a one-cycle clear of the error flags;
- a two-cycle protect sequence that marks one block;
- a one-cycle release that unprotects every block.

When a buffered-program command arrives, the block decides whether the array may start the operation. It rejects the command when an earlier error has not been cleared. It also rejects it when the target block is protected and the reset pin is at its normal high level. When the reset pin is at its elevated level, protection is bypassed.

The array, the erase and program timing, and the read paths are outside this block. The program/erase controller reports two things: a busy level, and whether the operation is suspended. The decoder uses them to decide which writes it acts on. The command code is the low data byte. The block index is the top `log2(NUM_BLOCKS)` bits of the write address.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After a synchronous reset the error flags are 0, no block is protected, and neither program pulse is asserted.
- R2: Clear-status (low byte 50h) clears the erase, program and protect error flags at the next edge. It acts when busy is low, or when busy is high with suspend high, at either reset-pin level.
- R3: Clear-status written while busy is high and suspend is low has no effect on the flags.
- R4: Protect-setup (60h) followed by a write of 01h protects the block addressed by the second write. No other block changes.
- R5: If the write after 60h carries any other low byte, the sequence ends and the erase and program error flags (status bits 5 and 4) are set. Protection is unchanged.
- R6: The single-cycle release command (47h) clears protection on every block.
- R7: Buffered-program (E8h) while status bit 5 or bit 4 is set gives a one-cycle reject pulse and leaves the flags unchanged.
- R8: E8h to a protected block with the reset pin at normal level gives a reject pulse and sets status bits 4 and 1.
- R9: E8h to a protected block with the reset pin at the elevated level gives an accept pulse.
- R10: E8h with no error flag set, to an unprotected block, gives an accept pulse one cycle after the write. Accept and reject are never asserted together.
- R11: The status byte is laid out as follows:
  - bit 7 is the inverse of busy;
  - bit 5 is the erase error;
  - bit 4 is the program error;
  - bit 1 is the protect error;
  - all other bits are 0.
- R12: While busy is high, every write other than clear-status is ignored: no pulse, no flag or protection change, and no progress of a pending protect sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Write address; the top bits select the block |
| wrData | input | 16 | Write data; the low byte is the command code |
| pecBusy | input | 1 | Program/erase controller is busy |
| pecSuspended | input | 1 | Controller operation is suspended |
| rpElevated | input | 1 | Reset pin is at the elevated voltage level |
| statusByte | output | 8 | Status byte (layout in R11) |
| progAccept | output | 1 | One-cycle pulse: buffered program may start |
| progReject | output | 1 | One-cycle pulse: buffered program refused |

## Verification
The bench builds the block with NUM_BLOCKS = 8 and ADDR_W = 10, so the block index is address bits 9..7. With only eight blocks, protect, release and per-block refusal can be checked on named blocks. It can also be shown that a block other than the target keeps its state. A behavioural model compares the status byte and both pulses on every cycle. The test sequence reaches:
- the sticky-error gate;
- the reset-pin bypass;
- clear during suspend;
- a broken protect sequence;
- writes dropped while the controller is busy.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam logic [7:0] CMD_CLEAR        = 8'h50;
  localparam logic [7:0] CMD_PROT_SETUP   = 8'h60;
  localparam logic [7:0] CMD_PROT_CONFIRM = 8'h01;
  localparam logic [7:0] CMD_UNPROT_ALL   = 8'h47;
  localparam logic [7:0] CMD_BUF_PROG     = 8'hE8;

  typedef struct packed {
    logic clearFlags;
    logic protectBlk;
    logic unprotectAll;
    logic seqFault;
    logic progGrant;
    logic progDenyErr;
    logic progDenyProt;
  } fcc_strobe_t;
endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int BLK_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic              pecBusy,
  input  logic              pecSuspended,
  input  logic              rpElevated,
  input  logic              stickyErr,
  input  logic              tgtProtected,
  output fcc_strobe_t       strb,
  output logic [BLK_W-1:0]  blkIdx
);
  logic       protPending;
  logic       protPendingNext;
  logic [7:0] cmdCode;
  logic       unusedBits;

  assign cmdCode    = wrData[7:0];
  assign blkIdx     = wrAddr[ADDR_W-1 -: BLK_W];
  assign unusedBits = ^{wrData[15:8], wrAddr[ADDR_W-BLK_W-1:0]};

  always_comb begin
    strb            = '0;
    protPendingNext = protPending;
    if (wrEn) begin
      if (!pecBusy) begin
        if (protPending) begin
          protPendingNext = 1'b0;
          if (cmdCode == CMD_PROT_CONFIRM) strb.protectBlk = 1'b1;
          else                             strb.seqFault   = 1'b1;
        end else begin
          unique case (cmdCode)
            CMD_CLEAR:      strb.clearFlags   = 1'b1;
            CMD_PROT_SETUP: protPendingNext   = 1'b1;
            CMD_UNPROT_ALL: strb.unprotectAll = 1'b1;
            CMD_BUF_PROG: begin
              if (stickyErr)                       strb.progDenyErr  = 1'b1;
              else if (tgtProtected && !rpElevated) strb.progDenyProt = 1'b1;
              else                                 strb.progGrant    = 1'b1;
            end
            default: ;
          endcase
        end
      end else if (pecSuspended && cmdCode == CMD_CLEAR) begin
        strb.clearFlags = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) protPending <= 1'b0;
    else     protPending <= protPendingNext;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb)); // R10
  AST_PEND_ENDS: assert property (@(posedge clk) disable iff (rst)
    (protPending && wrEn && !pecBusy) |=> !protPending); // R5
  AST_BUSY_HOLDS_PEND: assert property (@(posedge clk) disable iff (rst)
    (pecBusy && !strb.clearFlags) |=> $stable(protPending)); // R12
endmodule

// File: rtl/fcc_state.sv
module fcc_state
  import fcc_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int BLK_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  fcc_strobe_t           strb,
  input  logic [BLK_W-1:0]      blkIdx,
  output logic                  eraseErr,
  output logic                  progErr,
  output logic                  protErr,
  output logic [NUM_BLOCKS-1:0] protVec,
  output logic                  progAccept,
  output logic                  progReject
);
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_prot
    always_ff @(posedge clk) begin
      if (rst)                                              protVec[g] <= 1'b0;
      else if (strb.unprotectAll)                           protVec[g] <= 1'b0;
      else if (strb.protectBlk && blkIdx == BLK_W'(g))      protVec[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clearFlags) begin
      eraseErr <= 1'b0;
      progErr  <= 1'b0;
      protErr  <= 1'b0;
    end else if (strb.seqFault) begin
      eraseErr <= 1'b1;
      progErr  <= 1'b1;
    end else if (strb.progDenyProt) begin
      progErr  <= 1'b1;
      protErr  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      progAccept <= 1'b0;
      progReject <= 1'b0;
    end else begin
      progAccept <= strb.progGrant;
      progReject <= strb.progDenyErr | strb.progDenyProt;
    end
  end

  AST_DENY_SETS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    strb.progDenyProt |=> (progErr && protErr && progReject)); // R8
  AST_ERR_DENY_KEEPS: assert property (@(posedge clk) disable iff (rst)
    strb.progDenyErr |=> $stable({eraseErr, progErr, protErr})); // R7
  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (rst)
    strb.seqFault |=> (eraseErr && progErr)); // R5
  AST_UNPROT_ALL: assert property (@(posedge clk) disable iff (rst)
    strb.unprotectAll |=> (protVec == '0)); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    strb.clearFlags |=> !(eraseErr || progErr || protErr)); // R2
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int ADDR_W     = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic              pecBusy,
  input  logic              pecSuspended,
  input  logic              rpElevated,
  output logic [7:0]        statusByte,
  output logic              progAccept,
  output logic              progReject
);
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

  fcc_strobe_t           strb;
  logic [BLK_W-1:0]      blkIdx;
  logic                  eraseErr, progErr, protErr;
  logic [NUM_BLOCKS-1:0] protVec;
  logic                  tgtProtected;

  assign tgtProtected = (int'(blkIdx) < NUM_BLOCKS) ? protVec[blkIdx] : 1'b0;

  fcc_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_decode (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pecBusy(pecBusy), .pecSuspended(pecSuspended), .rpElevated(rpElevated),
    .stickyErr(eraseErr | progErr), .tgtProtected(tgtProtected),
    .strb(strb), .blkIdx(blkIdx)
  );

  fcc_state #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_state (
    .clk(clk), .rst(rst), .strb(strb), .blkIdx(blkIdx),
    .eraseErr(eraseErr), .progErr(progErr), .protErr(protErr),
    .protVec(protVec), .progAccept(progAccept), .progReject(progReject)
  );

  assign statusByte = {~pecBusy, 1'b0, eraseErr, progErr, 2'b00, protErr, 1'b0};

  AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (rst)
    progAccept |-> $past(!pecBusy)); // R12
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (statusByte[6:0] == 7'd0 && !progAccept && !progReject)); // R1
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(progAccept && progReject)); // R10
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int NB = 8;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [15:0]   wrData = '0;
  logic          pecBusy = 1'b0, pecSuspended = 1'b0, rpElevated = 1'b0;
  logic [7:0]    statusByte;
  logic          progAccept, progReject;

  int    checks = 0, errors = 0;
  string curReq = "R1";
  bit    finished = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.NUM_BLOCKS(NB), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pecBusy(pecBusy), .pecSuspended(pecSuspended), .rpElevated(rpElevated),
    .statusByte(statusByte), .progAccept(progAccept), .progReject(progReject)
  );

  // behavioural reference model
  bit mE5, mE4, mE1, mPend, mAcc, mRej;
  bit mProt [NB];

  always @(posedge clk) begin
    automatic int cmd = wrData[7:0];
    automatic int blk = wrAddr[AW-1:AW-3];
    if (rst) begin
      mE5 = 0; mE4 = 0; mE1 = 0; mPend = 0; mAcc = 0; mRej = 0;
      foreach (mProt[i]) mProt[i] = 0;
    end else begin
      mAcc = 0; mRej = 0;
      if (wrEn) begin
        if (!pecBusy) begin
          if (mPend) begin
            mPend = 0;
            if (cmd == 'h01) mProt[blk] = 1;
            else begin mE5 = 1; mE4 = 1; end
          end else if (cmd == 'h50) begin mE5 = 0; mE4 = 0; mE1 = 0; end
          else if (cmd == 'h60) mPend = 1;
          else if (cmd == 'h47) foreach (mProt[i]) mProt[i] = 0;
          else if (cmd == 'hE8) begin
            if (mE5 || mE4) mRej = 1;
            else if (mProt[blk] && !rpElevated) begin mRej = 1; mE4 = 1; mE1 = 1; end
            else mAcc = 1;
          end
        end else if (pecSuspended && cmd == 'h50) begin
          mE5 = 0; mE4 = 0; mE1 = 0;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    automatic logic [7:0] expS = {~pecBusy, 1'b0, mE5, mE4, 2'b00, mE1, 1'b0};
    if (!rst && !finished) begin
      chk(statusByte == expS, curReq, "status", statusByte, expS);
      chk(progAccept == mAcc, curReq, "accept", progAccept, mAcc);
      chk(progReject == mRej, curReq, "reject", progReject, mRej);
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; wrEn = 0; end
  endtask

  task automatic wr(int blk, int data);
    @(posedge clk); #1;
    wrEn = 1; wrAddr = AW'(blk << 7) | AW'(5); wrData = 16'(data);
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  // one write, then the pulses and the status are checked by name
  task automatic wrCheck(int blk, int data, string req, bit expAcc, bit expRej);
    wr(blk, data);
    @(negedge clk);
    chk(progAccept == expAcc && progReject == expRej, req, "pulses",
        {progAccept, progReject}, {expAcc, expRej});
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    chk(statusByte == 8'h80, "R1", "reset status", statusByte, 8'h80);
    chk(!progAccept && !progReject, "R1", "reset pulses", {progAccept, progReject}, 0);

    curReq = "R10"; wrCheck(2, 'hE8, "R10", 1, 0);
    idle(1);
    chk(!progAccept, "R10", "single pulse", progAccept, 0);

    curReq = "R4"; wr(2, 'h60); wr(2, 'h01);
    wrCheck(5, 'hE8, "R4", 1, 0);

    curReq = "R8"; wrCheck(2, 'hE8, "R8", 0, 1);
    chk(statusByte == 8'h92, "R8", "flags", statusByte, 8'h92);

    curReq = "R7"; wrCheck(3, 'hE8, "R7", 0, 1);
    chk(statusByte == 8'h92, "R7", "flags kept", statusByte, 8'h92);

    curReq = "R3"; pecBusy = 1; wr(0, 'h50);
    @(negedge clk);
    chk(statusByte == 8'h12, "R3", "clear ignored", statusByte, 8'h12);

    curReq = "R2"; pecSuspended = 1; wr(0, 'h50);
    @(negedge clk);
    chk(statusByte == 8'h00, "R2", "clear in suspend", statusByte, 8'h00);
    pecBusy = 0; pecSuspended = 0;

    curReq = "R9"; rpElevated = 1; wrCheck(2, 'hE8, "R9", 1, 0); rpElevated = 0;

    curReq = "R12"; pecBusy = 1;
    wrCheck(6, 'hE8, "R12", 0, 0);
    wr(6, 'h60); wr(6, 'h01); wr(0, 'h47);
    pecBusy = 0;
    wrCheck(6, 'hE8, "R12", 1, 0);
    wrCheck(2, 'hE8, "R12", 0, 1);

    curReq = "R2"; rpElevated = 1; wr(1, 'h50); rpElevated = 0;
    @(negedge clk);
    chk(statusByte == 8'h80, "R2", "clear at elevated", statusByte, 8'h80);

    curReq = "R5"; wr(4, 'h60); wr(4, 'h02);
    @(negedge clk);
    chk(statusByte == 8'hB0, "R5", "abort flags", statusByte, 8'hB0);
    wr(0, 'h50);
    wrCheck(4, 'hE8, "R5", 1, 0);

    curReq = "R6"; wr(7, 'h60); wr(7, 'h01);
    wr(0, 'h47);
    wrCheck(2, 'hE8, "R6", 1, 0);
    wrCheck(7, 'hE8, "R6", 1, 0);

    curReq = "R11"; pecBusy = 1;
    @(negedge clk);
    chk(statusByte == 8'h00, "R11", "busy bit", statusByte, 8'h00);
    pecBusy = 0;
    @(negedge clk);
    chk(statusByte == 8'h80, "R11", "ready bit", statusByte, 8'h80);

    idle(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule